// File: doc/BRIEF.md
# SPI Pattern-Memory Load Port

This block is an SPI slave that lets a host fill and inspect a waveform pattern memory of 16-bit words. Every exchange opens with a 16-bit command word: the top bit selects read or write, and the remaining fifteen bits give a register address. Data words follow, each exactly sixteen bits long. The memory sits in an address window whose top is a parameter and whose size is a power of two. With the defaults this is 4096 words, at addresses 0x6FFF down to 0x6000.

A write keeps going for as long as chip select stays low. After each completed word the address steps down by one, so a host can load the whole window in one burst, starting at the top address. A read is different. It returns one word per command and never steps the address, so reading the memory back takes one command per word. Chip select may go high for a single SCLK period between reads.

SCLK, chip select and MOSI are sampled in the system clock domain through two-stage synchronizers. SCLK must run at no more than a quarter of the system clock rate.

Top module: `pattern_spi_port`

## Requirements
- R1: SPI mode 0 (SCLK idles low); MOSI is sampled on the SCLK rising edge, MSB first. A command word carries bit 15 = 1 for a read and 0 for a write, and bits 14:0 hold the address. Every data word is 16 bits.
- R2: The memory holds 2^DEPTH_LOG2 words at addresses TOP_ADDR down to TOP_ADDR-2^DEPTH_LOG2+1. A word written to an address is returned by a later read of that same address.
- R3: During a write, each further complete 16-bit word sent while chip select stays low is stored at the address one below the previous word.
- R4: A full image loads in one chip-select-low burst that starts at TOP_ADDR and lasts exactly 16+16*2^DEPTH_LOG2 SCLK cycles.
- R5: If a write burst passes the bottom address, the remaining words are dropped and nothing wraps around. The word at TOP_ADDR keeps its value.
- R6: A read returns exactly one word on MISO, MSB first. Bit 15 is valid before the first rising edge of the data phase. Each later bit appears after the rising edge that ends the previous bit and is held through the next rising edge.
- R7: A read never auto-decrements. Extra SCLK cycles after its data word, with chip select still low, return 0 on MISO, and MOSI is ignored (nothing is written).
- R8: Back-to-back reads work with chip select high for one SCLK period between them, giving 33 SCLK periods per word read.
- R9: Raising chip select in the middle of a word aborts that word without writing it. The next chip-select-low period begins with a new command word.
- R10: A command whose address lies outside the memory window does not touch memory: writes are ignored without aliasing into the window, and reads return 0.
- R11: MISO is 0 after reset and whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial read data to host |

## Verification
The bench builds the block with DEPTH_LOG2 = 8 and the default TOP_ADDR of 0x6FFF, so the window is 0x6FFF down to 0x6F00. At this size a complete streamed load and a one-word-per-command readback of every address both fit inside the run. This makes it possible to check the full-load cycle count, the drop at the bottom of the window, and the no-wrap behaviour at the top on the same image. SCLK runs at exactly a quarter of the system clock, the tightest ratio allowed, so the MISO set-up margin and the one-period chip-select gap are tested at their limit.

// File: rtl/pattern_spi_port.sv
`timescale 1ns/1ps
module pattern_spi_port #(
  parameter int DATA_W     = 16,
  parameter int DEPTH_LOG2 = 12,
  parameter int TOP_ADDR   = 'h6FFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int ADDR_W = DATA_W - 1;
  localparam int DEPTH  = 1 << DEPTH_LOG2;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(TOP_ADDR);
  localparam logic [ADDR_W-1:0] BOT_A = ADDR_W'(TOP_ADDR - DEPTH + 1);

  function automatic logic in_rng(input logic [ADDR_W-1:0] a);
    return (a >= BOT_A) && (a <= TOP_A);
  endfunction

  logic [2:0] sclk_q;
  logic [1:0] cs_q, mosi_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      cs_q   <= {cs_q[0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  wire cs_s = cs_q[1];
  wire rise = sclk_q[1] & ~sclk_q[2];

  logic [DATA_W-2:0] sr;
  logic [DATA_W-1:0] miso_sr;
  logic [CNT_W-1:0]  cnt;
  logic              phase_dat, is_rd, rd_done;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] mem [DEPTH];

  wire [DATA_W-1:0]     word     = {sr, mosi_q[1]};
  wire [ADDR_W-1:0]     cmd_addr = word[ADDR_W-1:0];
  wire                  last     = rise && !cs_s && (cnt == CNT_W'(DATA_W - 1));
  wire [DEPTH_LOG2-1:0] idx_cmd  = DEPTH_LOG2'(cmd_addr - BOT_A);
  wire [DEPTH_LOG2-1:0] idx_cur  = DEPTH_LOG2'(addr - BOT_A);
  wire                  we       = last && phase_dat && !is_rd && in_rng(addr);
  wire [DATA_W-1:0]     rd_word  = in_rng(cmd_addr) ? mem[idx_cmd] : '0;

  always_ff @(posedge clk)
    if (we) mem[idx_cur] <= word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr        <= '0;
      miso_sr   <= '0;
      cnt       <= '0;
      phase_dat <= 1'b0;
      is_rd     <= 1'b0;
      rd_done   <= 1'b0;
      addr      <= '0;
    end else if (cs_s) begin
      cnt       <= '0;
      phase_dat <= 1'b0;
      rd_done   <= 1'b0;
      miso_sr   <= '0;
    end else if (rise) begin
      sr  <= word[DATA_W-2:0];
      cnt <= last ? '0 : cnt + 1'b1;
      if (phase_dat && is_rd && !rd_done) miso_sr <= miso_sr << 1;
      if (last) begin
        if (!phase_dat) begin
          phase_dat <= 1'b1;
          is_rd     <= word[DATA_W-1];
          addr      <= cmd_addr;
          if (word[DATA_W-1]) miso_sr <= rd_word;
        end else if (is_rd) begin
          rd_done <= 1'b1;
          miso_sr <= '0;
        end else if (addr != '0) begin
          addr <= addr - 1'b1;
        end
      end
    end

  assign spi_miso = miso_sr[DATA_W-1];

  // R11
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !spi_miso);

  // R6
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !cs_s) |=> $stable(spi_miso));

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && phase_dat && !is_rd) |=> (cs_s || addr <= $past(addr)));

  // R7
  rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_dat && is_rd) |=> $stable(addr));
endmodule

// File: tb/test_pattern_spi_port.sv
`timescale 1ns/1ps
module test_pattern_spi_port;
  localparam int DL    = 8;
  localparam int DEPTH = 1 << DL;
  localparam logic [14:0] TOP = 15'h6FFF;
  localparam logic [14:0] BOT = TOP - 15'(DEPTH - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  wire  spi_miso;
  int   n_chk = 0, n_bad = 0, nsclk = 0;

  always #2.5 clk = ~clk;

  pattern_spi_port #(.DATA_W(16), .DEPTH_LOG2(DL), .TOP_ADDR(int'(TOP))) i_pattern_spi_port (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  // {address, data written, value expected on read-back}
  localparam logic [46:0] VEC [6] = '{
    {15'h6FFF, 16'hA5C3, 16'hA5C3},
    {15'h6F00, 16'h0F0F, 16'h0F0F},
    {15'h6F80, 16'h8001, 16'h8001},
    {15'h7000, 16'h1357, 16'h0000},
    {15'h6EFF, 16'h2468, 16'h0000},
    {15'h0005, 16'hFFFF, 16'h0000}};

  function automatic logic [15:0] img(input logic [14:0] a);
    return {a[7:0], ~a[7:0]} ^ 16'h3C00;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic o);
    spi_mosi = b;
    #10;
    o = spi_miso;
    spi_sclk = 1'b1;
    nsclk++;
    #10;
    spi_sclk = 1'b0;
  endtask

  task automatic word_x(input logic [15:0] w, output logic [15:0] r);
    for (int i = 15; i >= 0; i--) bit_x(w[i], r[i]);
  endtask

  task automatic cs_end();
    spi_cs_n = 1'b1;
    #20;
  endtask

  task automatic wr1(input logic [14:0] a, input logic [15:0] d);
    logic [15:0] r;
    spi_cs_n = 1'b0;
    word_x({1'b0, a}, r);
    word_x(d, r);
    cs_end();
  endtask

  task automatic rd1(input logic [14:0] a, output logic [15:0] d);
    logic [15:0] r;
    spi_cs_n = 1'b0;
    word_x({1'b1, a}, r);
    word_x(16'h0000, d);
    cs_end();
  endtask

  initial begin
    #(150000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] r, x;
    realtime t0;
    #23 rst_n = 1'b1;
    #20;
    chk("R11 reset", {15'h0, spi_miso}, 16'h0);

    // R1 R2 R10: single write then single read per vector
    foreach (VEC[k]) begin
      wr1(VEC[k][46:32], VEC[k][31:16]);
      rd1(VEC[k][46:32], r);
      chk("R2/R10 vector", r, VEC[k][15:0]);
    end

    // R4 R3: stream a full image starting at the top
    nsclk = 0;
    spi_cs_n = 1'b0;
    word_x({1'b0, TOP}, r);
    for (int i = 0; i < DEPTH; i++) word_x(img(TOP - 15'(i)), r);
    cs_end();
    chk("R4 load cycles", 16'(nsclk), 16'(16 + 16 * DEPTH));

    // R8 R6 R3: read back every word, one command each
    t0 = $realtime;
    for (int i = 0; i < DEPTH; i++) begin
      rd1(TOP - 15'(i), r);
      chk("R3/R6 readback", r, img(TOP - 15'(i)));
    end
    chk("R8 read period", 16'(int'(($realtime - t0) / (20.0 * DEPTH))), 16'd33);
    chk("R11 idle", {15'h0, spi_miso}, 16'h0);

    // R10: out-of-range writes do not alias
    wr1(15'h7000, 16'hDEAD);
    wr1(15'h5F00, 16'hBEEF);
    rd1(BOT, r);
    chk("R10 no alias bottom", r, img(BOT));
    rd1(TOP, r);
    chk("R10 no alias top", r, img(TOP));

    // R9: abort mid data word, then a fresh command
    spi_cs_n = 1'b0;
    word_x({1'b0, 15'h6F10}, r);
    for (int i = 15; i >= 8; i--) bit_x(1'b1, x[i]);
    cs_end();
    rd1(15'h6F10, r);
    chk("R9 aborted word", r, img(15'h6F10));
    spi_cs_n = 1'b0;
    for (int i = 0; i < 5; i++) bit_x(1'b0, x[i]);
    cs_end();
    wr1(15'h6F11, 16'h600D);
    rd1(15'h6F11, r);
    chk("R9 new command", r, 16'h600D);

    // R7: no auto-decrement on read
    spi_cs_n = 1'b0;
    word_x({1'b1, 15'h6F20}, r);
    word_x(16'hFFFF, r);
    chk("R7 first word", r, img(15'h6F20));
    word_x(16'hFFFF, r);
    chk("R7 extra bits", r, 16'h0000);
    cs_end();
    rd1(15'h6F20, r);
    chk("R7 no write", r, img(15'h6F20));
    rd1(15'h6F1F, r);
    chk("R7 next addr", r, img(15'h6F1F));

    // R5: burst passing the bottom
    spi_cs_n = 1'b0;
    word_x({1'b0, BOT + 15'd1}, r);
    word_x(16'h1111, r);
    word_x(16'h2222, r);
    word_x(16'h3333, r);
    word_x(16'h4444, r);
    cs_end();
    rd1(BOT + 15'd1, r);
    chk("R5 word0", r, 16'h1111);
    rd1(BOT, r);
    chk("R5 word1", r, 16'h2222);
    rd1(TOP, r);
    chk("R5 top kept", r, img(TOP));
    rd1(TOP - 15'd1, r);
    chk("R5 top-1 kept", r, img(TOP - 15'd1));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule